// File: doc/BRIEF.md
# Autonomous Prefetch Address Generator

This block drives the memory request channel of a processor core. Left alone, it runs a program counter forward one 32-bit word at a time and issues an instruction fetch for each value. Each fetch address it hands to memory is also written into a small address queue. Downstream logic pops that queue as instructions come back, so every instruction is paired with the address it was read from. Memory must answer requests in the order they were issued; the block relies on that ordering.

The execution side can feed two kinds of request into the stream. A branch target goes out to memory in the same cycle it is accepted, and the counter then carries on from the word after it. A load or store address borrows the request channel for exactly one transfer. The counter is not moved by it, so fetching picks up at the next sequential word.

Fetching pauses while the address queue is full or memory is not ready. Every request carries a kind code, so returning data can be steered to the right place. The design checks at elaboration that the instruction buffer, whose depth is given as a parameter, holds at least three more entries than the address queue. A smaller buffer could deadlock the pipeline.

Top module: `fetch_addr_gen`

## Requirements
- R1: After reset the queue is empty (`pcq_valid` low) and the first request is a fetch (`req_kind` 00) at `RESET_PC`.
- R2: With no load/store or branch input, each accepted fetch is followed by a fetch at the previous address plus 4.
- R3: An accepted branch is issued in the same cycle as a fetch at `br_addr`, and the next fetch is at `br_addr` plus 4.
- R4: A load/store request is issued at `dx_addr` with `req_kind` 01 for a read or 10 for a write, and the next fetch uses the unchanged sequential address.
- R5: When a load/store and a branch are both valid, the load/store goes out and `br_ready` stays low; the branch is taken in a later slot.
- R6: Every accepted fetch address is pushed into the queue, and `pcq_pc` presents the addresses oldest first, advancing on each `pcq_pop`.
- R7: While the queue holds `PCQ_DEPTH` entries, no fetch is requested (`req_valid` low unless a load/store is valid), and load/store requests still go out.
- R8: In a cycle where `req_ready` is low, nothing is accepted: the counter, the queue contents and any pending branch stay as they are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dx_valid | input | 1 | Load/store address is valid |
| dx_write | input | 1 | Load/store is a write (1) or a read (0) |
| dx_addr | input | AW | Load/store address |
| dx_ready | output | 1 | Load/store address accepted this cycle |
| br_valid | input | 1 | Branch target is valid |
| br_addr | input | AW | Branch target address |
| br_ready | output | 1 | Branch target accepted this cycle |
| req_valid | output | 1 | Memory request is valid |
| req_ready | input | 1 | Memory accepts a request |
| req_addr | output | AW | Memory request address |
| req_kind | output | 2 | 00 fetch, 01 data read, 10 data write |
| pcq_valid | output | 1 | Address queue is not empty |
| pcq_pc | output | AW | Oldest queued fetch address |
| pcq_pop | input | 1 | Remove the oldest queued address |

## Verification
The bench builds the block with a four-entry address queue and a reset address of 0x100. With that depth, a few fetches fill the queue, so the bench reaches the full-queue stall. It then drives a load/store and a branch against the full queue, and drains the queue to confirm that addresses leave in issue order. A cycle with the request channel not ready, and a cycle with a branch and a store valid together, are placed among ordinary fetches, so the counter's hold and resume behaviour is checked on the exact word that follows.

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen #(
  parameter int AW = 32,
  parameter int PCQ_DEPTH = 4,
  parameter int IBUF_DEPTH = 8,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dx_valid,
  input  logic          dx_write,
  input  logic [AW-1:0] dx_addr,
  output logic          dx_ready,
  input  logic          br_valid,
  input  logic [AW-1:0] br_addr,
  output logic          br_ready,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [1:0]    req_kind,
  output logic          pcq_valid,
  output logic [AW-1:0] pcq_pc,
  input  logic          pcq_pop
);
  localparam int PW = (PCQ_DEPTH > 1) ? $clog2(PCQ_DEPTH) : 1;
  localparam int CW = $clog2(PCQ_DEPTH + 1);
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [1:0] K_FETCH = 2'b00;
  localparam logic [1:0] K_READ  = 2'b01;
  localparam logic [1:0] K_WRITE = 2'b10;

  generate
    if (IBUF_DEPTH < PCQ_DEPTH + 3) begin : g_depth_bad
      $error("instruction buffer must be at least 3 entries deeper than the address queue");
    end
  endgenerate

  logic [AW-1:0] pc;
  logic [AW-1:0] q_mem [PCQ_DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  logic full, fetch_go, pop;
  logic [AW-1:0] fetch_addr;

  assign full       = (cnt == CW'(PCQ_DEPTH));
  assign fetch_addr = br_valid ? br_addr : pc;
  assign fetch_go   = !dx_valid && !full && req_ready;
  assign pop        = pcq_pop && pcq_valid;

  assign req_valid = dx_valid || !full;
  assign req_addr  = dx_valid ? dx_addr : fetch_addr;
  assign req_kind  = dx_valid ? (dx_write ? K_WRITE : K_READ) : K_FETCH;
  assign dx_ready  = dx_valid && req_ready;
  assign br_ready  = fetch_go;

  assign pcq_valid = (cnt != '0);
  assign pcq_pc    = q_mem[rd_ptr];

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(PCQ_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= RESET_PC;
    end else if (fetch_go) begin
      pc <= fetch_addr + STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (fetch_go) wr_ptr <= wrap_inc(wr_ptr);
      if (pop)      rd_ptr <= wrap_inc(rd_ptr);
      if (fetch_go && !pop)      cnt <= cnt + 1'b1;
      else if (!fetch_go && pop) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fetch_go) q_mem[wr_ptr] <= fetch_addr;
  end
endmodule

module fetch_addr_gen_chk #(
  parameter int AW = 32,
  parameter int PCQ_DEPTH = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dx_valid,
  input logic          br_valid,
  input logic          br_ready,
  input logic [AW-1:0] br_addr,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_kind,
  input logic [AW-1:0] req_addr,
  input logic          pcq_pop,
  input logic          pcq_valid,
  input logic [AW-1:0] pc,
  input logic [CW-1:0] cnt
);
  logic fetch_acc;
  assign fetch_acc = req_valid && req_ready && (req_kind == 2'b00);

  p_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_acc && !br_valid) |=> (pc == $past(pc) + AW'(4)));

  p_branch_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready) |-> (req_valid && req_kind == 2'b00 && req_addr == br_addr));

  p_branch_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready) |=> (pc == $past(br_addr) + AW'(4)));

  p_data_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 2'b00) |-> dx_valid);

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dx_valid |=> $stable(pc));

  p_data_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dx_valid |-> !br_ready);

  p_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_acc && !(pcq_pop && pcq_valid)) |=> (cnt == $past(cnt) + 1'b1));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(PCQ_DEPTH) && !dx_valid) |-> !req_valid);

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(pc));
endmodule

bind fetch_addr_gen fetch_addr_gen_chk #(
  .AW(AW), .PCQ_DEPTH(PCQ_DEPTH), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dx_valid(dx_valid), .br_valid(br_valid),
  .br_ready(br_ready), .br_addr(br_addr), .req_valid(req_valid),
  .req_ready(req_ready), .req_kind(req_kind), .req_addr(req_addr),
  .pcq_pop(pcq_pop), .pcq_valid(pcq_valid), .pc(pc), .cnt(cnt)
);

// File: tb/fetch_addr_gen_bench.sv
module fetch_addr_gen_bench;
  logic clk = 0, rst_n = 0;
  logic dx_valid = 0, dx_write = 0, br_valid = 0, req_ready = 0, pcq_pop = 0;
  logic [31:0] dx_addr = '0, br_addr = '0;
  logic dx_ready, br_ready, req_valid, pcq_valid;
  logic [31:0] req_addr, pcq_pc;
  logic [1:0] req_kind;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  fetch_addr_gen #(.AW(32), .PCQ_DEPTH(4), .IBUF_DEPTH(7), .RESET_PC(32'h100)) u_fetch_addr_gen (
    .clk(clk), .rst_n(rst_n), .dx_valid(dx_valid), .dx_write(dx_write),
    .dx_addr(dx_addr), .dx_ready(dx_ready), .br_valid(br_valid),
    .br_addr(br_addr), .br_ready(br_ready), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_kind(req_kind),
    .pcq_valid(pcq_valid), .pcq_pc(pcq_pc), .pcq_pop(pcq_pop)
  );

  // {dv, dw, bv, rdy, addr[31:0], exp_valid, exp_kind[1:0], exp_addr[31:0], exp_br_ready}
  localparam int NV = 10;
  localparam logic [71:0] VEC [NV] = '{
    {4'b0001, 32'h0,    1'b1, 2'b00, 32'h100,  1'b1}, // R1 R2 first fetch
    {4'b0000, 32'h0,    1'b1, 2'b00, 32'h104,  1'b0}, // R8 not ready
    {4'b0001, 32'h0,    1'b1, 2'b00, 32'h104,  1'b1}, // R8 R2 held address goes
    {4'b1001, 32'h2000, 1'b1, 2'b01, 32'h2000, 1'b0}, // R4 read
    {4'b0001, 32'h0,    1'b1, 2'b00, 32'h108,  1'b1}, // R4 fetch resumes
    {4'b1111, 32'h3000, 1'b1, 2'b10, 32'h3000, 1'b0}, // R5 R4 write beats branch
    {4'b0011, 32'h400,  1'b1, 2'b00, 32'h400,  1'b1}, // R3 R5 branch next slot
    {4'b0001, 32'h0,    1'b0, 2'b00, 32'h0,    1'b0}, // R7 full
    {4'b1001, 32'h5000, 1'b1, 2'b01, 32'h5000, 1'b0}, // R7 data while full
    {4'b0011, 32'h800,  1'b0, 2'b00, 32'h0,    1'b0}  // R7 branch waits while full
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_idle(input logic rdy, input logic pop);
    dx_valid = 0; dx_write = 0; br_valid = 0; req_ready = rdy; pcq_pop = pop;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    drive_idle(1'b0, 1'b0);
    #1;
    chk("R1 pcq_valid", {31'b0, pcq_valid}, 32'h0);
    chk("R1 req_valid", {31'b0, req_valid}, 32'h1);
    chk("R1 req_addr", req_addr, 32'h100);
    chk("R1 req_kind", {30'b0, req_kind}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      dx_valid = VEC[i][71]; dx_write = VEC[i][70]; br_valid = VEC[i][69];
      req_ready = VEC[i][68]; dx_addr = VEC[i][67:36]; br_addr = VEC[i][67:36];
      pcq_pop = 0;
      #1;
      chk($sformatf("vec%0d req_valid", i), {31'b0, req_valid}, {31'b0, VEC[i][35]});
      if (VEC[i][35]) begin
        chk($sformatf("vec%0d req_kind", i), {30'b0, req_kind}, {30'b0, VEC[i][34:33]});
        chk($sformatf("vec%0d req_addr", i), req_addr, VEC[i][32:1]);
      end
      chk($sformatf("vec%0d br_ready", i), {31'b0, br_ready}, {31'b0, VEC[i][0]});
    end

    // R6 drain in issue order, without new fetches
    for (int k = 0; k < 4; k++) begin
      logic [31:0] exp_pc;
      exp_pc = (k == 3) ? 32'h400 : 32'h100 + 32'(4 * k);
      @(negedge clk);
      drive_idle(1'b0, 1'b1);
      #1;
      chk("R6 pcq_valid", {31'b0, pcq_valid}, 32'h1);
      chk("R6 pcq_pc order", pcq_pc, exp_pc);
    end
    @(negedge clk);
    drive_idle(1'b0, 1'b0);
    #1;
    chk("R6 queue drained", {31'b0, pcq_valid}, 32'h0);
    chk("R3 after branch fetch continues", req_addr, 32'h404);

    // R6 newly pushed address appears at head
    @(negedge clk);
    drive_idle(1'b1, 1'b0);
    @(negedge clk);
    drive_idle(1'b0, 1'b0);
    #1;
    chk("R6 push visible", pcq_pc, 32'h404);
    chk("R2 next sequential", req_addr, 32'h408);

    // R1 reset again mid-run
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 re-reset pcq_valid", {31'b0, pcq_valid}, 32'h0);
    chk("R1 re-reset req_addr", req_addr, 32'h100);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule